// File: doc/BRIEF.md
# Accumulator Logic and Rotate Unit

This unit executes the bitwise, compare, rotate and carry-control operations of an 8-bit accumulator datapath. Each cycle it is given an operation code, the current accumulator value, one ready-made 8-bit operand and the current flag vector. From these it forms a new accumulator value and a new flag vector. Both are captured in output registers on a rising clock edge while the execute strobe is high. The operand source (register file, memory or immediate byte) is resolved upstream, and the unit never sees it.

Each operation class has its own flag rule. Bitwise AND forces the half-carry flag high. OR and XOR clear it. Compare only derives flags from a subtraction and reloads the accumulator unchanged. Rotates alter only the carry flag. Complement of the accumulator touches no flag.

The flag vector is five bits wide and ordered {S, Z, AC, P, CY}: CY at bit 0, P at bit 1, AC at bit 2, Z at bit 3 and S at bit 4. The accumulator is 8 bits wide.

Top module: `alr_unit`

## Requirements
- R1: Compare (op code 3) loads the accumulator input unchanged, sets CY=1 when accumulator < operand (unsigned), sets Z=1 when they are equal, and clears both when accumulator > operand.
- R2: For compare, S is bit 7 of the 8-bit difference accumulator minus operand, and P is 1 when that difference has an even count of ones. AC is the carry out of the low nibble of accumulator + inverted operand + 1.
- R3: AND (op code 0) loads accumulator & operand, forces CY (bit 0) to 0 and AC (bit 2) to 1.
- R4: OR (op code 1) and XOR (op code 2) load the bitwise result and force both CY (bit 0) and AC (bit 2) to 0.
- R5: Circular rotate left (op code 4) moves bit 7 into bit 0 and into CY. Circular rotate right (op code 5) moves bit 0 into bit 7 and into CY. S, Z, AC and P keep their input values.
- R6: Rotate left through carry (op code 6) puts the input CY into bit 0 and bit 7 into CY. Rotate right through carry (op code 7) puts the input CY into bit 7 and bit 0 into CY. S, Z, AC and P keep their input values.
- R7: Complement (op code 8) loads the bitwise inverse of the accumulator, and all five flags keep their input values.
- R8: Carry invert (op code 9) and carry set (op code 10) change only CY (inverted or forced to 1). The accumulator input and the other four flags pass through unchanged.
- R9: For AND, OR and XOR, S (bit 4) equals result bit 7, Z (bit 3) is 1 when the result is zero, and P (bit 1) is 1 when the result holds an even number of ones.
- R10: With the execute strobe low, the registered accumulator and flags keep their values. Op codes 11 to 15 load the accumulator and flag inputs unchanged.
- R11: An active-low reset clears the accumulator and all flags at once, with no clock edge required. Register updates resume only after its release has passed through a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute strobe; registers update on a clock edge while high |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Prepared operand byte |
| flg_i | input | 5 | Current flags {S, Z, AC, P, CY} |
| acc_q | output | 8 | Registered new accumulator |
| flg_q | output | 5 | Registered new flags {S, Z, AC, P, CY} |

## Verification
The assertions take the accumulator, operand, flag and op-code inputs as stable and known in every cycle where the strobe is high. They also assume that the strobe stays low until the synchronised reset has been released. The stimulus changes every input only at falling edges, and each operation is held for one full cycle. The bench waits several cycles after reset release before its first strobe. Operand patterns are chosen to reach the compare boundaries (equal, just below, just above, zero against all ones), a zero result, and both odd and even parity.

// File: rtl/alr_pkg.sv
`timescale 1ns/1ps
package alr_pkg;

  localparam int OP_W   = 4;
  localparam int FLAG_W = 5;

  // flag vector bit positions
  localparam int FL_CY = 0;
  localparam int FL_P  = 1;
  localparam int FL_AC = 2;
  localparam int FL_Z  = 3;
  localparam int FL_S  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND   = 4'd0,
    OP_OR    = 4'd1,
    OP_XOR   = 4'd2,
    OP_CMP   = 4'd3,
    OP_ROL   = 4'd4,
    OP_ROR   = 4'd5,
    OP_ROLC  = 4'd6,
    OP_RORC  = 4'd7,
    OP_INV   = 4'd8,
    OP_FLIPC = 4'd9,
    OP_SETC  = 4'd10
  } alr_op_e;

endpackage

// File: rtl/alr_rst_sync.sv
`timescale 1ns/1ps
module alr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/alr_bitwise.sv
`timescale 1ns/1ps
module alr_bitwise
  import alr_pkg::*;
#(
  parameter int W = 8
) (
  input  alr_op_e           op,
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  output logic [W-1:0]      res,
  output logic [FLAG_W-1:0] flg
);

  logic [W-1:0] and_v;
  logic [W-1:0] or_v;
  logic [W-1:0] xor_v;

  assign and_v = a & b;
  assign or_v  = a | b;
  assign xor_v = a ^ b;

  always_comb begin
    case (op)
      OP_AND:  res = and_v;
      OP_OR:   res = or_v;
      default: res = xor_v;
    endcase
  end

  // flags derived from the result; AC only high for AND, CY always low
  always_comb begin
    flg        = '0;
    flg[FL_S]  = res[W-1];
    flg[FL_Z]  = ~|res;
    flg[FL_P]  = ~^res;
    flg[FL_AC] = (op == OP_AND);
    flg[FL_CY] = 1'b0;
  end

endmodule

// File: rtl/alr_compare.sv
`timescale 1ns/1ps
module alr_compare
  import alr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  output logic [FLAG_W-1:0] flg
);

  localparam int NIB = W / 2;

  logic [W:0]     full_sum;
  logic [NIB:0]   low_sum;
  logic [W-1:0]   diff;
  logic           carry_out;

  // subtraction as a + ~b + 1 over the full width and the low half
  assign full_sum  = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
  assign low_sum   = {1'b0, a[NIB-1:0]} + {1'b0, ~b[NIB-1:0]} + {{NIB{1'b0}}, 1'b1};
  assign diff      = full_sum[W-1:0];
  assign carry_out = full_sum[W];

  always_comb begin
    flg        = '0;
    flg[FL_S]  = diff[W-1];
    flg[FL_Z]  = ~|diff;
    flg[FL_P]  = ~^diff;
    flg[FL_AC] = low_sum[NIB];
    flg[FL_CY] = ~carry_out;   // borrow means a < b
  end

endmodule

// File: rtl/alr_rotate.sv
`timescale 1ns/1ps
module alr_rotate
  import alr_pkg::*;
#(
  parameter int W = 8
) (
  input  alr_op_e           op,
  input  logic [W-1:0]      a,
  input  logic [FLAG_W-1:0] flg_in,
  output logic [W-1:0]      res,
  output logic [FLAG_W-1:0] flg
);

  logic cy_in;
  logic top_bit;
  logic low_bit;

  assign cy_in   = flg_in[FL_CY];
  assign top_bit = a[W-1];
  assign low_bit = a[0];

  always_comb begin
    res = a;
    flg = flg_in;
    case (op)
      OP_ROL: begin
        res        = {a[W-2:0], top_bit};
        flg[FL_CY] = top_bit;
      end
      OP_ROR: begin
        res        = {low_bit, a[W-1:1]};
        flg[FL_CY] = low_bit;
      end
      OP_ROLC: begin
        res        = {a[W-2:0], cy_in};
        flg[FL_CY] = top_bit;
      end
      OP_RORC: begin
        res        = {cy_in, a[W-1:1]};
        flg[FL_CY] = low_bit;
      end
      OP_INV: begin
        res = ~a;
      end
      OP_FLIPC: begin
        flg[FL_CY] = ~cy_in;
      end
      OP_SETC: begin
        flg[FL_CY] = 1'b1;
      end
      default: begin
        res = a;
        flg = flg_in;
      end
    endcase
  end

endmodule

// File: rtl/alr_unit.sv
`timescale 1ns/1ps
module alr_unit
  import alr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [W-1:0]      acc_i,
  input  logic [W-1:0]      opnd_i,
  input  logic [FLAG_W-1:0] flg_i,
  output logic [W-1:0]      acc_q,
  output logic [FLAG_W-1:0] flg_q
);

  typedef enum logic [1:0] {
    CL_BIT,
    CL_CMP,
    CL_ROT,
    CL_PASS
  } op_class_e;

  alr_op_e           op;
  op_class_e         op_cl;
  logic              rst_sync_n;

  logic [W-1:0]      bit_res;
  logic [FLAG_W-1:0] bit_flg;
  logic [FLAG_W-1:0] cmp_flg;
  logic [W-1:0]      rot_res;
  logic [FLAG_W-1:0] rot_flg;

  logic [W-1:0]      acc_nx;
  logic [FLAG_W-1:0] flg_nx;

  assign op = alr_op_e'(op_i);

  alr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  alr_bitwise #(.W(W)) u_bit (
    .op  (op),
    .a   (acc_i),
    .b   (opnd_i),
    .res (bit_res),
    .flg (bit_flg)
  );

  alr_compare #(.W(W)) u_cmp (
    .a   (acc_i),
    .b   (opnd_i),
    .flg (cmp_flg)
  );

  alr_rotate #(.W(W)) u_rot (
    .op     (op),
    .a      (acc_i),
    .flg_in (flg_i),
    .res    (rot_res),
    .flg    (rot_flg)
  );

  // operation class decode
  always_comb begin
    case (op)
      OP_AND, OP_OR, OP_XOR:               op_cl = CL_BIT;
      OP_CMP:                              op_cl = CL_CMP;
      OP_ROL, OP_ROR, OP_ROLC, OP_RORC,
      OP_INV, OP_FLIPC, OP_SETC:           op_cl = CL_ROT;
      default:                             op_cl = CL_PASS;
    endcase
  end

  // next-state selection
  always_comb begin
    case (op_cl)
      CL_BIT: begin
        acc_nx = bit_res;
        flg_nx = bit_flg;
      end
      CL_CMP: begin
        acc_nx = acc_i;
        flg_nx = cmp_flg;
      end
      CL_ROT: begin
        acc_nx = rot_res;
        flg_nx = rot_flg;
      end
      default: begin
        acc_nx = acc_i;
        flg_nx = flg_i;
      end
    endcase
  end

  // state registers with explicit execute enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q <= '0;
      flg_q <= '0;
    end else if (exec_i) begin
      acc_q <= acc_nx;
      flg_q <= flg_nx;
    end
  end

endmodule

// File: rtl/alr_checks.sv
`timescale 1ns/1ps
module alr_checks
  import alr_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exec_i,
  input logic [OP_W-1:0]   op_i,
  input logic [W-1:0]      acc_i,
  input logic [W-1:0]      opnd_i,
  input logic [FLAG_W-1:0] flg_i,
  input logic [W-1:0]      acc_q,
  input logic [FLAG_W-1:0] flg_q
);

  // R1: compare keeps accumulator, CY = less-than, Z = equal
  a_r1_cmp_order: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_CMP) |=>
      (acc_q == $past(acc_i)) &&
      (flg_q[FL_CY] == ($past(acc_i) < $past(opnd_i))) &&
      (flg_q[FL_Z]  == ($past(acc_i) == $past(opnd_i))));

  // R3: AND forces AC high and CY low
  a_r3_and_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_AND) |=>
      (flg_q[FL_AC] == 1'b1) && (flg_q[FL_CY] == 1'b0) &&
      (acc_q == ($past(acc_i) & $past(opnd_i))));

  // R4: OR and XOR clear AC and CY
  a_r4_orxor_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && (op_i == OP_OR || op_i == OP_XOR)) |=>
      (flg_q[FL_AC] == 1'b0) && (flg_q[FL_CY] == 1'b0));

  // R5 and R6: every rotate leaves S, Z, AC, P at their input values
  a_r5_rot_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i >= OP_ROL && op_i <= OP_RORC) |=>
      (flg_q[FLAG_W-1:1] == $past(flg_i[FLAG_W-1:1])));

  // R7: complement inverts the accumulator, flags untouched
  a_r7_inv: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_INV) |=>
      (acc_q == ~$past(acc_i)) && (flg_q == $past(flg_i)));

  // R8: carry set forces CY only
  a_r8_setc: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_SETC) |=>
      (flg_q[FL_CY] == 1'b1) && (acc_q == $past(acc_i)) &&
      (flg_q[FLAG_W-1:1] == $past(flg_i[FLAG_W-1:1])));

  // R10: no strobe, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_i) |=> ($stable(acc_q) && $stable(flg_q)));

endmodule

bind alr_unit alr_checks #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .exec_i (exec_i),
  .op_i   (op_i),
  .acc_i  (acc_i),
  .opnd_i (opnd_i),
  .flg_i  (flg_i),
  .acc_q  (acc_q),
  .flg_q  (flg_q)
);

// File: tb/tb_alr_unit.sv
`timescale 1ns/1ps
module tb_alr_unit;

  logic       clk;
  logic       rst_n;
  logic       exec_i;
  logic [3:0] op_i;
  logic [7:0] acc_i;
  logic [7:0] opnd_i;
  logic [4:0] flg_i;
  logic [7:0] acc_q;
  logic [4:0] flg_q;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  alr_unit dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .exec_i (exec_i),
    .op_i   (op_i),
    .acc_i  (acc_i),
    .opnd_i (opnd_i),
    .flg_i  (flg_i),
    .acc_q  (acc_q),
    .flg_q  (flg_q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // flags are {S, Z, AC, P, CY}
  task automatic check(input string tag, input logic [7:0] ea, input logic [4:0] ef);
    n_chk++;
    if (acc_q !== ea || flg_q !== ef) begin
      n_fail++;
      $display("FAIL %s: acc=%02h flags=%05b, expected acc=%02h flags=%05b",
               tag, acc_q, flg_q, ea, ef);
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                     input logic [4:0] f, input logic [7:0] ea, input logic [4:0] ef,
                     input string tag);
    @(negedge clk);
    op_i = op; acc_i = a; opnd_i = b; flg_i = f; exec_i = 1'b1;
    @(negedge clk);
    exec_i = 1'b0;
    check(tag, ea, ef);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 reset clears", 8'h00, 5'b00000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 after release", 8'h00, 5'b00000);
  endtask

  task automatic t_async_reset;
    run(4'd8, 8'h0F, 8'h00, 5'b11111, 8'hF0, 5'b11111, "R11 preload");
    #1;
    rst_n = 1'b0;
    #1;
    check("R11 async clear", 8'h00, 5'b00000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_and;
    run(4'd0, 8'hF0, 8'h3C, 5'b11001, 8'h30, 5'b00110, "R3 and nonzero");
    run(4'd0, 8'h55, 8'hAA, 5'b10000, 8'h00, 5'b01110, "R3 R9 and zero");
  endtask

  task automatic t_or_xor;
    run(4'd1, 8'h80, 8'h01, 5'b00101, 8'h81, 5'b10010, "R4 or");
    run(4'd2, 8'hFF, 8'h7F, 5'b11111, 8'h80, 5'b10000, "R4 xor");
    run(4'd2, 8'h5A, 8'h5A, 5'b00101, 8'h00, 5'b01010, "R4 xor zero");
  endtask

  task automatic t_parity;
    run(4'd1, 8'h07, 8'h00, 5'b11111, 8'h07, 5'b00000, "R9 odd parity");
    run(4'd2, 8'hC0, 8'h3F, 5'b00001, 8'hFF, 5'b10010, "R9 even parity");
  endtask

  task automatic t_compare;
    run(4'd3, 8'h10, 8'h20, 5'b00000, 8'h10, 5'b10111, "R1 R2 cmp below");
    run(4'd3, 8'h42, 8'h42, 5'b10001, 8'h42, 5'b01110, "R1 R2 cmp equal");
    run(4'd3, 8'h90, 8'h01, 5'b01111, 8'h90, 5'b10000, "R1 R2 cmp above");
    run(4'd3, 8'h00, 8'hFF, 5'b11110, 8'h00, 5'b00001, "R1 R2 cmp zero vs ones");
  endtask

  task automatic t_rot_circ;
    run(4'd4, 8'h81, 8'h00, 5'b01010, 8'h03, 5'b01011, "R5 rotate left");
    run(4'd5, 8'h01, 8'h00, 5'b10100, 8'h80, 5'b10101, "R5 rotate right");
  endtask

  task automatic t_rot_carry;
    run(4'd6, 8'h80, 8'h00, 5'b00110, 8'h00, 5'b00111, "R6 left thru carry 0");
    run(4'd6, 8'h01, 8'h00, 5'b00001, 8'h03, 5'b00000, "R6 left thru carry 1");
    run(4'd7, 8'h01, 8'h00, 5'b11000, 8'h00, 5'b11001, "R6 right thru carry 0");
    run(4'd7, 8'h00, 8'h00, 5'b00001, 8'h80, 5'b00000, "R6 right thru carry 1");
  endtask

  task automatic t_complement;
    run(4'd8, 8'h3C, 8'hFF, 5'b10101, 8'hC3, 5'b10101, "R7 complement");
  endtask

  task automatic t_carry_ops;
    run(4'd9,  8'h12, 8'h00, 5'b01011, 8'h12, 5'b01010, "R8 invert carry");
    run(4'd9,  8'h12, 8'h00, 5'b01010, 8'h12, 5'b01011, "R8 invert carry back");
    run(4'd10, 8'h34, 8'h00, 5'b10100, 8'h34, 5'b10101, "R8 set carry");
  endtask

  task automatic t_hold;
    run(4'd0, 8'hA5, 8'hFF, 5'b00000, 8'hA5, 5'b10110, "R10 load before hold");
    @(negedge clk);
    op_i = 4'd8; acc_i = 8'h00; opnd_i = 8'h00; flg_i = 5'b11111; exec_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 no strobe holds", 8'hA5, 5'b10110);
    run(4'd13, 8'h77, 8'h00, 5'b11011, 8'h77, 5'b11011, "R10 spare code passes");
    run(4'd15, 8'h01, 8'hFF, 5'b00100, 8'h01, 5'b00100, "R10 spare code 15");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    exec_i = 1'b0;
    op_i   = 4'd0;
    acc_i  = 8'h00;
    opnd_i = 8'h00;
    flg_i  = 5'b00000;
    t_reset();
    t_and();
    t_or_xor();
    t_parity();
    t_compare();
    t_rot_circ();
    t_rot_carry();
    t_complement();
    t_carry_ops();
    t_hold();
    t_async_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule